// File: doc/BRIEF.md
# Per-Channel DC Offset Detector

This block watches the output offset of several amplifier channels while they play. Each channel delivers a signed digital offset sample, qualified by a common valid strobe. A channel that keeps its offset magnitude at or above a host-programmed level for a host-programmed number of consecutive valid samples is latched as faulty. Once latched, the fault stays until the host clears that one channel.

Shutdown on a DC fault is optional and is controlled by a single enable bit. The host register that holds this bit resets to zero, so after reset a fault is only reported. With the bit set, only the faulty channel receives a shutdown request, and the shared FAULT contribution goes high while any shutdown request is active.

Each channel has its own small state machine with three named states:
- **ST_QUIET**: no qualifying offset.
- **ST_PERSIST**: the offset is at or above the level and the run is being counted.
- **ST_TRIPPED**: the fault is latched.

The transitions are:
- **start**: QUIET to PERSIST, on a valid sample at or above the level.
- **drop**: PERSIST to QUIET, on a valid sample below the level.
- **trip**: QUIET or PERSIST to TRIPPED, when the run length reaches the hold time.
- **release**: TRIPPED to QUIET, on the channel's clear bit.

Top module: `dc_offset_watch`

## Requirements
- R1: After reset, every fault flag and shutdown request is 0, `fault_out` is 0, and every run count is zero.
- R2: A valid sample counts toward a run when its magnitude is greater than or equal to `level`. A magnitude equal to `level` counts, and one below it does not.
- R3: A channel trips on the valid sample that brings its run of consecutive at-or-above samples to `hold_time`. Its flag reads 1 right after that clock edge.
- R4: The magnitude is the absolute value of the two's-complement sample. Channel i occupies `smp_offset[i*SW +: SW]`, and the most negative code (-2048 at the default width) has magnitude 2048.
- R5: With `sd_enable` at 0, a trip sets only the fault flag. Both `sd_req` and `fault_out` stay 0.
- R6: A valid sample below `level` on an untripped channel resets that channel's run count to zero.
- R7: Cycles with `smp_valid` at 0 neither advance nor reset any run count.
- R8: A tripped flag holds until that channel's bit in `clr` is 1, and samples arriving meanwhile are ignored. A clear bit affects only its own channel, and has no effect on a channel that has not tripped.
- R9: `sd_req[i]` is 1 exactly when channel i is tripped and `sd_enable` is 1. Other channels are not affected.
- R10: `fault_out` is 1 exactly when at least one `sd_req` bit is 1.
- R11: A `hold_time` of 0 behaves as 1, so a single qualifying sample trips the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Offset samples on all channels are valid this cycle |
| smp_offset | input | NCH*SW | Packed signed offset samples, channel i at bits i*SW +: SW |
| level | input | SW | Unsigned magnitude threshold |
| hold_time | input | TW | Required run length in valid samples |
| sd_enable | input | 1 | Turns the shutdown action on |
| clr | input | NCH | Per-channel clear, active for one cycle |
| fault_flag | output | NCH | Latched DC fault per channel |
| sd_req | output | NCH | Per-channel shutdown request |
| fault_out | output | 1 | Contribution to the shared FAULT line |

## Verification
The channels are driven together with different patterns in each phase, so that each pattern is told apart from the others:
- **Magnitude tests.** A run exactly at the level separates `>=` from `>`. A run one code below the level checks the other side of the threshold. A negative run and the most negative code check the absolute value.
- **Run-count tests.** A run broken by one low sample shows that the count restarts. Cycles with the strobe low, inserted inside a run, show that the count is held rather than cleared.
- **Clear and shutdown tests.** Single-channel clears, a clear aimed at a channel that has not tripped, and toggling the enable show which channel a clear or a shutdown reaches. A zero hold time checks the trip on a single sample.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_PERSIST = 2'd1,
        ST_TRIPPED = 2'd2
    } dcw_state_e;

endpackage

// File: rtl/dcw_mag_cmp.sv
module dcw_mag_cmp #(
    parameter int SW = 12
) (
    input  logic [SW-1:0] smp,
    input  logic [SW-1:0] level,
    output logic          at_level
);

    logic [SW-1:0] mag;

    always_comb begin
        // Two's-complement negate; the most negative code maps to 2^(SW-1).
        mag      = smp[SW-1] ? (~smp + SW'(1)) : smp;
        at_level = (mag >= level);
    end

endmodule

// File: rtl/dcw_chan.sv
module dcw_chan
    import dcw_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          at_level,
    input  logic [TW-1:0] hold_time,
    input  logic          clr,
    output logic          tripped
);

    dcw_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW:0]   hold_eff;
    logic [TW:0]   cnt_inc;

    always_comb begin
        hold_eff = (hold_time == '0) ? (TW+1)'(1) : {1'b0, hold_time};
        cnt_inc  = {1'b0, cnt_q} + (TW+1)'(1);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_QUIET: begin
                if (valid && at_level) begin
                    if (cnt_inc >= hold_eff) begin
                        state_d = ST_TRIPPED;           // trip
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_PERSIST;           // start
                        cnt_d   = cnt_inc[TW-1:0];
                    end
                end
            end
            ST_PERSIST: begin
                if (valid) begin
                    if (!at_level) begin
                        state_d = ST_QUIET;             // drop
                        cnt_d   = '0;
                    end else if (cnt_inc >= hold_eff) begin
                        state_d = ST_TRIPPED;           // trip
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_inc[TW-1:0];
                    end
                end
            end
            ST_TRIPPED: begin
                if (clr) begin
                    state_d = ST_QUIET;                 // release
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_QUIET;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        tripped = (state_q == ST_TRIPPED);
    end

    AST_TRIP_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tripped) |-> $past(valid && at_level)); // R3
    AST_HOLD_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && !clr) |=> tripped); // R8
    AST_BELOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !at_level && !tripped) |=> (cnt_q == '0) && !tripped); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !tripped) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/dcw_fault_merge.sv
module dcw_fault_merge #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] tripped,
    input  logic           sd_enable,
    output logic [NCH-1:0] sd_req,
    output logic           fault_out
);

    always_comb begin
        sd_req    = tripped & {NCH{sd_enable}};
        fault_out = |sd_req;
    end

endmodule

// File: rtl/dc_offset_watch.sv
module dc_offset_watch #(
    parameter int NCH = 4,
    parameter int SW  = 12,
    parameter int TW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [NCH*SW-1:0] smp_offset,
    input  logic [SW-1:0]     level,
    input  logic [TW-1:0]     hold_time,
    input  logic              sd_enable,
    input  logic [NCH-1:0]    clr,
    output logic [NCH-1:0]    fault_flag,
    output logic [NCH-1:0]    sd_req,
    output logic              fault_out
);

    logic [NCH-1:0] at_level;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dcw_mag_cmp #(.SW(SW)) u_cmp (
            .smp      (smp_offset[g*SW +: SW]),
            .level    (level),
            .at_level (at_level[g])
        );
        dcw_chan #(.TW(TW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid     (smp_valid),
            .at_level  (at_level[g]),
            .hold_time (hold_time),
            .clr       (clr[g]),
            .tripped   (fault_flag[g])
        );
    end

    dcw_fault_merge #(.NCH(NCH)) u_merge (
        .tripped   (fault_flag),
        .sd_enable (sd_enable),
        .sd_req    (sd_req),
        .fault_out (fault_out)
    );

    AST_SD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (|sd_req) |-> sd_enable); // R9
    AST_FAULT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_out) |-> (sd_enable && (|fault_flag))); // R10

endmodule

// File: tb/test_dc_offset_watch.sv
module test_dc_offset_watch;

    localparam int NCH = 4;
    localparam int SW  = 12;
    localparam int TW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [NCH*SW-1:0] smp_offset = '0;
    logic [SW-1:0]     level = '0;
    logic [TW-1:0]     hold_time = '0;
    logic              sd_enable = 1'b0;
    logic [NCH-1:0]    clr = '0;
    logic [NCH-1:0]    fault_flag;
    logic [NCH-1:0]    sd_req;
    logic              fault_out;

    always #5 clk = ~clk;

    dc_offset_watch #(.NCH(NCH), .SW(SW), .TW(TW)) i_dc_offset_watch (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_offset(smp_offset),
        .level(level), .hold_time(hold_time), .sd_enable(sd_enable), .clr(clr),
        .fault_flag(fault_flag), .sd_req(sd_req), .fault_out(fault_out)
    );

    typedef struct {
        logic [NCH-1:0] fl;
        logic [NCH-1:0] sd;
        logic           fo;
        string          tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    int   mcnt[NCH];
    bit   mtrip[NCH];
    bit   done = 0;

    task automatic compare(input exp_t e);
        n_chk++;
        if (fault_flag !== e.fl || sd_req !== e.sd || fault_out !== e.fo) begin
            n_bad++;
            $display("FAIL %s: flag=%b sd=%b fo=%b expected flag=%b sd=%b fo=%b",
                     e.tag, fault_flag, sd_req, fault_out, e.fl, e.sd, e.fo);
        end
    endtask

    // Monitor: after each edge, compare against the oldest expected item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    // Driver: drives one cycle at the falling edge and pushes the expected outcome.
    task automatic apply(input bit v, input int s0, input int s1, input int s2, input int s3,
                         input logic [NCH-1:0] c, input string tag);
        int   sv[NCH];
        exp_t e;
        int   h;
        sv[0] = s0; sv[1] = s1; sv[2] = s2; sv[3] = s3;
        @(negedge clk);
        smp_valid = v;
        clr       = c;
        for (int i = 0; i < NCH; i++) smp_offset[i*SW +: SW] = SW'(sv[i]);
        h = (hold_time == 0) ? 1 : int'(hold_time);
        for (int i = 0; i < NCH; i++) begin
            if (mtrip[i]) begin
                if (c[i]) begin
                    mtrip[i] = 0;
                    mcnt[i]  = 0;
                end
            end else if (v) begin
                int mag;
                mag = (sv[i] < 0) ? -sv[i] : sv[i];
                if (mag >= int'(level)) begin
                    mcnt[i]++;
                    if (mcnt[i] >= h) begin
                        mtrip[i] = 1;
                        mcnt[i]  = 0;
                    end
                end else begin
                    mcnt[i] = 0;
                end
            end
        end
        for (int i = 0; i < NCH; i++) e.fl[i] = mtrip[i];
        e.sd  = e.fl & {NCH{sd_enable}};
        e.fo  = |e.sd;
        e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #2;
        smp_valid = 1'b0;
        clr       = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            mcnt[i]  = 0;
            mtrip[i] = 0;
        end
        level     = 12'd100;
        hold_time = 16'd3;
        sd_enable = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        n_chk++;
        if (fault_flag !== '0 || sd_req !== '0 || fault_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: flag=%b sd=%b fo=%b expected all zero",
                     fault_flag, sd_req, fault_out);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5: ch0 at level, ch1 negative at level, ch2 one below
        apply(1, 100, -100, 99, 0, 4'b0000, "R2 run sample 1");
        apply(1, 100, -100, 99, 0, 4'b0000, "R3 run sample 2 no trip yet");
        apply(1, 100, -100, 99, 0, 4'b0000, "R4 R3 trip on third, R5 no shutdown");
        apply(1, 300, 300, 99, 0, 4'b0000, "R2 below level never trips");

        // R6: ch3 run broken by a low sample
        apply(1, 0, 0, 0, 150, 4'b0000, "R6 ch3 sample 1");
        apply(1, 0, 0, 0, 150, 4'b0000, "R6 ch3 sample 2");
        apply(1, 0, 0, 0, 50, 4'b0000, "R6 ch3 low sample restarts");
        apply(1, 0, 0, 0, 150, 4'b0000, "R6 ch3 restart 1");
        apply(1, 0, 0, 0, 150, 4'b0000, "R6 ch3 restart 2 no trip");

        // R7: invalid cycles hold the count of 2
        for (int k = 0; k < 5; k++) apply(0, 0, 0, 0, -4, 4'b0000, "R7 strobe low holds count");
        apply(1, 0, 0, 0, 150, 4'b0000, "R7 third valid sample trips ch3");

        // R8: clears
        apply(0, 0, 0, 0, 0, 4'b0001, "R8 clear ch0 only");
        apply(0, 0, 0, 0, 0, 4'b0100, "R8 clear of untripped ch2 no effect");
        apply(1, 500, 500, 500, 500, 4'b0000, "R8 tripped channels ignore samples");

        // R9 R10: enable shutdown
        sd_enable = 1'b1;
        apply(0, 0, 0, 0, 0, 4'b0000, "R9 R10 shutdown on tripped channels only");
        apply(0, 0, 0, 0, 0, 4'b1111, "R10 all clear drops fault_out");
        apply(0, 0, 0, 0, 0, 4'b0000, "R9 cleared channels no shutdown");

        // R11 R4: zero hold time, most negative code
        level     = 12'd2048;
        hold_time = 16'd0;
        apply(1, 2047, 0, -2048, 0, 4'b0000, "R11 R4 single sample trips at -2048");
        apply(0, 0, 0, 0, 0, 4'b0000, "R9 only ch2 requests shutdown");
        sd_enable = 1'b0;
        apply(0, 0, 0, 0, 0, 4'b0000, "R5 disabling removes request");
        sd_enable = 1'b1;
        apply(0, 0, 0, 0, 0, 4'b0100, "R10 clear ch2 drops fault_out");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule